// File: doc/BRIEF.md
# SPI Flash Instruction Frame Decoder

This block is the device-side front end of a serial flash memory. It watches the serial clock, the active-low chip enable and the serial data input, all oversampled by a fast system clock. It assembles an 8-bit instruction byte and then collects the address, dummy and data bytes that the instruction calls for. A write-type instruction (erase, program, status write) is reported as a one-cycle command strobe, together with its captured address and data. The strobe is issued only when chip enable rises on the byte boundary that closes the frame. A read-type instruction produces an open-ended stream on the serial output. The stream comes from a combinational read-data port that the memory array drives, from a status input, or from identification constants held as parameters.

The decoder is a single state machine. IDLE waits for a chip-enable fall, which moves it to OPCODE from any state. OPCODE classifies the first byte and goes to ADDR (three address bytes follow), WDATA (one data byte follows), STREAM (a read with no address), ARMED (the frame is already complete) or DRAIN (an unknown instruction). ADDR moves on after its last address byte: to DUMMY for the fast read, to STREAM for the other reads, to WDATA for byte program, and to ARMED for the erases. DUMMY passes one byte and then goes to STREAM. WDATA goes to ARMED after its byte. In ARMED, any further clock bit moves the machine to DRAIN. A chip-enable rise sends every state to IDLE, and the command is committed only when the frame is complete at that moment.

Top module: `spi_flash_frame_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, miso_oe and cmd_valid are 0.
- R2: Opcode 20h, 52h or D8h, followed by three address bytes (MSB first) and a chip-enable rise, gives a strobe with cmd_kind 1, 2 or 3. cmd_addr has bits [11:0], [14:0] or [15:0] cleared, in that order.
- R3: Opcode 60h or C7h, with no further bytes, followed by a chip-enable rise, gives a strobe with cmd_kind 4 and cmd_addr 0.
- R4: Opcode 02h with three address bytes and one data byte gives cmd_kind 5 with the full address and the data in cmd_data. Opcode 01h with one data byte gives cmd_kind 6 with the data in cmd_data and cmd_addr 0.
- R5: A write-type frame with missing bytes, with extra bytes, or cut off part-way through a byte produces no strobe.
- R6: cmd_valid is high for exactly one system clock per committed frame.
- R7: Opcode 03h with address A streams the bytes rd_data(A), rd_data(A+1) and onward without limit, MSB first. Each bit is valid at the SCK rise. rd_addr presents the current byte address, and no strobe is issued.
- R8: Opcode 0Bh behaves like 03h, except that one dummy byte comes between the address and the first data byte.
- R9: Opcode 05h repeats status_in on miso, byte after byte, until chip enable rises.
- R10: Opcodes 90h and ABh take three address bytes. They then return MFR_ID if address bit 0 is 0 and DEV_ID if it is 1, and continue by alternating between the two.
- R11: Opcode 9Fh returns the three JEDEC_ID bytes, most significant byte first, and repeats them every three bytes.
- R12: miso_oe is 1 only in the output phase of a read while chip enable is low. It is 0 during the opcode and address phases and after chip enable rises.
- R13: An unknown opcode gives no strobe and no output, and the next frame is decoded normally.
- R14: A frame whose last bit is sampled in the same cycle as the chip-enable rise is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip enable |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, updated after each SCK fall |
| miso_oe | output | 1 | Output enable for miso; 0 means high impedance |
| rd_addr | output | 24 | Byte address of the current memory read |
| rd_data | input | 8 | Array byte at rd_addr, combinational |
| status_in | input | 8 | Status byte that is streamed by opcode 05h |
| cmd_valid | output | 1 | One-cycle strobe for a committed write-type command |
| cmd_kind | output | 3 | 1 sector erase, 2 32 KB erase, 3 64 KB erase, 4 chip erase, 5 byte program, 6 status write |
| cmd_addr | output | 24 | Captured address, aligned to the erase size |
| cmd_data | output | 8 | Captured data byte |

## Verification
The completion of the final byte and the chip-enable rise can be detected in the same system clock. When that happens, the state machine must judge the frame by the state it would enter, not the state it is in. The bench provokes this by raising SCK for the last bit of a status write and raising chip enable on the same clock edge. It expects exactly one strobe carrying kind 6 and the data byte just received. A companion case raises chip enable together with one extra bit after a complete chip erase and expects no strobe.

// File: rtl/sfd_pkg.sv
package sfd_pkg;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SECT  = 3'd1,
        K_BLK32 = 3'd2,
        K_BLK64 = 3'd3,
        K_CHIP  = 3'd4,
        K_PROG  = 3'd5,
        K_WRSR  = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_STAT,
        SRC_ID,
        SRC_JID
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_WDATA,
        ST_STREAM,
        ST_ARMED,
        ST_DRAIN
    } state_e;

    typedef struct packed {
        logic  known;
        logic  has_addr;
        logic  dummy;
        logic  wdata;
        logic  is_read;
        src_e  src;
        kind_e kind;
    } op_info_t;

    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r = '0;
        case (op)
            8'h03: begin r.known = 1'b1; r.has_addr = 1'b1; r.is_read = 1'b1; r.src = SRC_MEM; end
            8'h0B: begin r.known = 1'b1; r.has_addr = 1'b1; r.is_read = 1'b1; r.dummy = 1'b1; r.src = SRC_MEM; end
            8'h20: begin r.known = 1'b1; r.has_addr = 1'b1; r.kind = K_SECT; end
            8'h52: begin r.known = 1'b1; r.has_addr = 1'b1; r.kind = K_BLK32; end
            8'hD8: begin r.known = 1'b1; r.has_addr = 1'b1; r.kind = K_BLK64; end
            8'h60, 8'hC7: begin r.known = 1'b1; r.kind = K_CHIP; end
            8'h02: begin r.known = 1'b1; r.has_addr = 1'b1; r.wdata = 1'b1; r.kind = K_PROG; end
            8'h01: begin r.known = 1'b1; r.wdata = 1'b1; r.kind = K_WRSR; end
            8'h05: begin r.known = 1'b1; r.is_read = 1'b1; r.src = SRC_STAT; end
            8'h90, 8'hAB: begin r.known = 1'b1; r.has_addr = 1'b1; r.is_read = 1'b1; r.src = SRC_ID; end
            8'h9F: begin r.known = 1'b1; r.is_read = 1'b1; r.src = SRC_JID; end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sfd_pin_sampler.sv
module sfd_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_now,
    output logic rx_en,
    output logic mosi_s
);
    // bit 2 = sck, bit 1 = cs_n, bit 0 = mosi
    localparam logic [2:0] IDLE_PINS = 3'b010;

    logic [2:0] cur_q;
    logic [2:0] prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= IDLE_PINS;
            prv_q <= IDLE_PINS;
        end else begin
            cur_q <= {sck, cs_n, mosi};
            prv_q <= cur_q;
        end
    end

    assign sck_rise = cur_q[2] & ~prv_q[2];
    assign sck_fall = ~cur_q[2] & prv_q[2];
    assign cs_fall  = ~cur_q[1] & prv_q[1];
    assign cs_rise  = cur_q[1] & ~prv_q[1];
    assign cs_now   = cur_q[1];
    // a bit that arrives together with the enable rise still counts
    assign rx_en    = ~prv_q[1];
    assign mosi_s   = cur_q[0];

endmodule

// File: rtl/sfd_byte_rx.sv
module sfd_byte_rx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         rise,
    input  logic         din,
    output logic         byte_done,
    output logic [W-1:0] byte_val
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt_q;
    logic [W-2:0]  sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (rise) begin
            cnt_q <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + 1'b1;
            sh_q  <= {sh_q[W-3:0], din};
        end
    end

    assign byte_done = en & rise & (cnt_q == CW'(W - 1));
    assign byte_val  = {sh_q, din};

endmodule

// File: rtl/sfd_byte_tx.sv
module sfd_byte_tx #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         fall,
    input  logic [W-1:0] src_byte,
    output logic         taken,
    output logic         dout
);
    localparam int CW = $clog2(W);

    logic [CW-1:0] cnt_q;
    logic [W-2:0]  sh_q;

    assign taken = en & fall & (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
            dout  <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (fall) begin
            cnt_q <= (cnt_q == CW'(W - 1)) ? '0 : cnt_q + 1'b1;
            if (cnt_q == '0) begin
                dout <= src_byte[W-1];
                sh_q <= src_byte[W-2:0];
            end else begin
                dout <= sh_q[W-2];
                sh_q <= {sh_q[W-3:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/spi_flash_frame_decoder.sv
module spi_flash_frame_decoder
    import sfd_pkg::*;
#(
    parameter int          ADDR_BYTES = 3,
    parameter int          SECTOR_LSB = 12,
    parameter int          BLK32_LSB  = 15,
    parameter int          BLK64_LSB  = 16,
    parameter logic [7:0]  MFR_ID     = 8'h5E,
    parameter logic [7:0]  DEV_ID     = 8'h17,
    parameter logic [23:0] JEDEC_ID   = 24'h5E2614
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sck,
    input  logic                    cs_n,
    input  logic                    mosi,
    output logic                    miso,
    output logic                    miso_oe,
    output logic [8*ADDR_BYTES-1:0] rd_addr,
    input  logic [7:0]              rd_data,
    input  logic [7:0]              status_in,
    output logic                    cmd_valid,
    output logic [2:0]              cmd_kind,
    output logic [8*ADDR_BYTES-1:0] cmd_addr,
    output logic [7:0]              cmd_data
);
    localparam int AW  = 8 * ADDR_BYTES;
    localparam int BIW = $clog2(ADDR_BYTES + 1);
    localparam logic [AW-1:0] MASK_SECT  = ~((AW'(1) << SECTOR_LSB) - AW'(1));
    localparam logic [AW-1:0] MASK_BLK32 = ~((AW'(1) << BLK32_LSB) - AW'(1));
    localparam logic [AW-1:0] MASK_BLK64 = ~((AW'(1) << BLK64_LSB) - AW'(1));

    logic sck_rise, sck_fall, cs_fall, cs_rise, cs_now, rx_en, mosi_s;
    logic byte_done;
    logic [7:0] rx_byte;
    logic tx_taken;
    logic [7:0] src_byte;

    state_e   state, nxt;
    op_info_t info;
    logic     commit;

    kind_e          kind_q;
    src_e           src_q;
    logic           read_q, dummy_q, wdata_q;
    logic [AW-1:0]  addr_q;
    logic [7:0]     data_q;
    logic [BIW-1:0] byte_idx;
    logic [1:0]     id_idx;
    logic           last_addr;

    kind_e         kind_eff;
    logic [AW-1:0] addr_eff;
    logic [7:0]    data_eff;

    sfd_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
        .cs_rise(cs_rise), .cs_now(cs_now), .rx_en(rx_en), .mosi_s(mosi_s)
    );

    sfd_byte_rx #(.W(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .rise(sck_rise), .din(mosi_s),
        .byte_done(byte_done), .byte_val(rx_byte)
    );

    sfd_byte_tx #(.W(8)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(miso_oe), .fall(sck_fall),
        .src_byte(src_byte), .taken(tx_taken), .dout(miso)
    );

    assign info      = classify(rx_byte);
    assign last_addr = (byte_idx == BIW'(ADDR_BYTES - 1));
    assign miso_oe   = (state == ST_STREAM) && !cs_now;
    assign rd_addr   = addr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and commit decision
    always_comb begin
        nxt    = state;
        commit = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_OPCODE: if (byte_done) begin
                if (!info.known)       nxt = ST_DRAIN;
                else if (info.has_addr) nxt = ST_ADDR;
                else if (info.wdata)    nxt = ST_WDATA;
                else if (info.is_read)  nxt = ST_STREAM;
                else                    nxt = ST_ARMED;
            end
            ST_ADDR: if (byte_done && last_addr) begin
                if (read_q)       nxt = dummy_q ? ST_DUMMY : ST_STREAM;
                else if (wdata_q) nxt = ST_WDATA;
                else              nxt = ST_ARMED;
            end
            ST_DUMMY:  if (byte_done) nxt = ST_STREAM;
            ST_WDATA:  if (byte_done) nxt = ST_ARMED;
            ST_STREAM: ;
            ST_ARMED:  if (sck_rise && rx_en) nxt = ST_DRAIN;
            ST_DRAIN:  ;
            default:   nxt = ST_IDLE;
        endcase
        if (cs_rise) begin
            commit = (nxt == ST_ARMED);
            nxt    = ST_IDLE;
        end
        if (cs_fall) nxt = ST_OPCODE;
    end

    // values as they stand once the byte of this cycle is absorbed
    always_comb begin
        kind_eff = (state == ST_OPCODE) ? info.kind : kind_q;
        addr_eff = (state == ST_ADDR) ? AW'({addr_q, rx_byte}) : addr_q;
        data_eff = (state == ST_WDATA) ? rx_byte : data_q;
    end

    function automatic logic [AW-1:0] align(input kind_e k, input logic [AW-1:0] a);
        case (k)
            K_SECT:  return a & MASK_SECT;
            K_BLK32: return a & MASK_BLK32;
            K_BLK64: return a & MASK_BLK64;
            default: return a;
        endcase
    endfunction

    always_comb begin
        unique case (src_q)
            SRC_MEM:  src_byte = rd_data;
            SRC_STAT: src_byte = status_in;
            SRC_ID:   src_byte = id_idx[0] ? DEV_ID : MFR_ID;
            SRC_JID:  src_byte = (id_idx == 2'd0) ? JEDEC_ID[23:16] :
                                 (id_idx == 2'd1) ? JEDEC_ID[15:8] : JEDEC_ID[7:0];
            default:  src_byte = 8'h00;
        endcase
    end

    // frame datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q    <= K_NONE;
            src_q     <= SRC_MEM;
            read_q    <= 1'b0;
            dummy_q   <= 1'b0;
            wdata_q   <= 1'b0;
            addr_q    <= '0;
            data_q    <= '0;
            byte_idx  <= '0;
            id_idx    <= '0;
            cmd_valid <= 1'b0;
            cmd_kind  <= 3'd0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (cs_fall) begin
                addr_q   <= '0;
                data_q   <= '0;
                byte_idx <= '0;
                id_idx   <= '0;
            end
            if (state == ST_OPCODE && byte_done) begin
                kind_q  <= info.kind;
                src_q   <= info.src;
                read_q  <= info.is_read;
                dummy_q <= info.dummy;
                wdata_q <= info.wdata;
            end
            if (state == ST_ADDR && byte_done) begin
                addr_q   <= AW'({addr_q, rx_byte});
                byte_idx <= byte_idx + 1'b1;
                if (last_addr) id_idx <= {1'b0, rx_byte[0]};
            end
            if (state == ST_WDATA && byte_done) data_q <= rx_byte;
            if (tx_taken) begin
                unique case (src_q)
                    SRC_MEM:  addr_q <= addr_q + 1'b1;
                    SRC_STAT: ;
                    SRC_ID:   id_idx[0] <= ~id_idx[0];
                    SRC_JID:  id_idx <= (id_idx == 2'd2) ? 2'd0 : id_idx + 1'b1;
                    default:  ;
                endcase
            end
            if (commit) begin
                cmd_valid <= 1'b1;
                cmd_kind  <= kind_eff;
                cmd_addr  <= align(kind_eff, addr_eff);
                cmd_data  <= data_eff;
            end
        end
    end

    // R12: output enable is released once chip enable has risen
    assert_oe_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe);

    // R6: the strobe never lasts two cycles
    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2: only the six write kinds are ever reported
    assert_kind_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_kind != 3'd0 && cmd_kind <= 3'd6));

    // R2: a sector erase address is aligned to the sector
    assert_sector_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd1) |-> (cmd_addr[SECTOR_LSB-1:0] == '0));

    // R2: a 64 KB erase address is aligned to the block
    assert_blk64_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_kind == 3'd3) |-> (cmd_addr[BLK64_LSB-1:0] == '0));

    // R7: a read stream never ends in a strobe
    assert_no_read_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(state) != ST_STREAM));

endmodule

// File: tb/spi_flash_frame_decoder_tb.sv
module spi_flash_frame_decoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] addr;
        logic [7:0]  data;
        logic [1:0]  shape;   // 0 op only, 1 op+addr, 2 op+addr+data, 3 op+data
        logic        exp_v;
        logic [2:0]  kind;
        logic [23:0] eaddr;
        logic [7:0]  edata;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'h20, 24'h123ABC, 8'h00, 2'd1, 1'b1, 3'd1, 24'h123000, 8'h00},
        '{8'h52, 24'h12FFFF, 8'h00, 2'd1, 1'b1, 3'd2, 24'h128000, 8'h00},
        '{8'hD8, 24'h12FFFF, 8'h00, 2'd1, 1'b1, 3'd3, 24'h120000, 8'h00},
        '{8'h33, 24'h000000, 8'h00, 2'd1, 1'b0, 3'd0, 24'h000000, 8'h00},
        '{8'h60, 24'h000000, 8'h00, 2'd0, 1'b1, 3'd4, 24'h000000, 8'h00},
        '{8'hC7, 24'h000000, 8'h00, 2'd0, 1'b1, 3'd4, 24'h000000, 8'h00},
        '{8'h02, 24'h00A5C3, 8'h3C, 2'd2, 1'b1, 3'd5, 24'h00A5C3, 8'h3C},
        '{8'h01, 24'h000000, 8'h9E, 2'd3, 1'b1, 3'd6, 24'h000000, 8'h9E},
        '{8'h02, 24'h001234, 8'h00, 2'd1, 1'b0, 3'd0, 24'h000000, 8'h00},
        '{8'h20, 24'h000000, 8'h55, 2'd3, 1'b0, 3'd0, 24'h000000, 8'h00},
        '{8'h03, 24'h000100, 8'h00, 2'd1, 1'b0, 3'd0, 24'h000000, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic miso, miso_oe, cmd_valid;
    logic [23:0] rd_addr, cmd_addr;
    logic [7:0]  rd_data, cmd_data;
    logic [7:0]  status_in = 8'hC3;
    logic [2:0]  cmd_kind;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int hi_cycles = 0;
    logic prev_v = 1'b0;
    logic [2:0]  cap_kind;
    logic [23:0] cap_addr;
    logic [7:0]  cap_data;
    bit finished = 1'b0;

    function automatic logic [7:0] mem(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign rd_data = mem(rd_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_flash_frame_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .status_in(status_in), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            hi_cycles <= hi_cycles + 1;
            cap_kind  <= cmd_kind;
            cap_addr  <= cmd_addr;
            cap_data  <= cmd_data;
        end
        if (cmd_valid && !prev_v) pulses <= pulses + 1;
        prev_v <= cmd_valid;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input bit cs_with_last, input int nbits);
        rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk); mosi = tx[i];
            repeat (HALF - 1) @(negedge clk);
            rx[i] = miso;
            @(negedge clk); sck = 1'b1;
            if (cs_with_last && i == 8 - nbits) cs_n = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic put(input logic [7:0] b);
        logic [7:0] dummy;
        xfer(b, dummy, 1'b0, 8);
    endtask

    task automatic get(output logic [7:0] b);
        xfer(8'h00, b, 1'b0, 8);
    endtask

    task automatic frame_begin();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_end();
        repeat (4) @(negedge clk); cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic put_addr(input logic [23:0] a);
        put(a[23:16]); put(a[15:8]); put(a[7:0]);
    endtask

    function automatic string vtag(input int i);
        case (i)
            0, 1, 2: return "R2";
            3:       return "R13";
            4, 5:    return "R3";
            6, 7:    return "R4";
            8, 9:    return "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int p0;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        check(miso_oe == 1'b0 && cmd_valid == 1'b0, "R1 in reset", {30'd0, miso_oe, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(miso_oe == 1'b0 && cmd_valid == 1'b0, "R1 after reset", {30'd0, miso_oe, cmd_valid}, 0);

        // table of write-type and ignored frames
        for (int i = 0; i < NV; i++) begin
            p0 = pulses;
            frame_begin();
            put(VECS[i].op);
            if (VECS[i].shape == 2'd1 || VECS[i].shape == 2'd2) put_addr(VECS[i].addr);
            if (VECS[i].shape == 2'd2 || VECS[i].shape == 2'd3) put(VECS[i].data);
            frame_end();
            check((pulses - p0) == int'(VECS[i].exp_v), vtag(i), pulses - p0, {31'd0, VECS[i].exp_v});
            if (VECS[i].exp_v) begin
                check(cap_kind == VECS[i].kind && cap_addr == VECS[i].eaddr, vtag(i),
                      {5'd0, cap_kind, cap_addr}, {5'd0, VECS[i].kind, VECS[i].eaddr});
                if (VECS[i].kind >= 3'd5)
                    check(cap_data == VECS[i].edata, vtag(i), cap_data, VECS[i].edata);
            end
        end
        check(hi_cycles == pulses, "R6 strobe width", hi_cycles, pulses);

        // R7: memory read crossing a page of the low byte
        p0 = pulses;
        frame_begin();
        put(8'h03); put(8'h00); put(8'h01);
        check(miso_oe == 1'b0, "R12 oe during address", miso_oe, 0);
        put(8'hFE);
        check(miso_oe == 1'b1, "R12 oe during stream", miso_oe, 1);
        for (int k = 0; k < 4; k++) begin
            get(b);
            check(b == mem(24'h0001FE + 24'(k)), "R7 read byte", b, mem(24'h0001FE + 24'(k)));
        end
        frame_end();
        check(miso_oe == 1'b0, "R12 oe after enable rise", miso_oe, 0);
        check(pulses == p0, "R7 no strobe on read", pulses - p0, 0);

        // R8: fast read with dummy byte
        frame_begin();
        put(8'h0B); put_addr(24'h004321); put(8'hFF);
        for (int k = 0; k < 3; k++) begin
            get(b);
            check(b == mem(24'h004321 + 24'(k)), "R8 fast read byte", b, mem(24'h004321 + 24'(k)));
        end
        frame_end();

        // R9: status stream
        frame_begin();
        put(8'h05);
        for (int k = 0; k < 3; k++) begin
            get(b);
            check(b == 8'hC3, "R9 status byte", b, 8'hC3);
        end
        frame_end();

        // R10: identification pair
        frame_begin();
        put(8'h90); put_addr(24'h000000);
        get(b); check(b == 8'h5E, "R10 id A0=0 first", b, 8'h5E);
        get(b); check(b == 8'h17, "R10 id A0=0 second", b, 8'h17);
        get(b); check(b == 8'h5E, "R10 id A0=0 third", b, 8'h5E);
        frame_end();
        frame_begin();
        put(8'hAB); put_addr(24'h000001);
        get(b); check(b == 8'h17, "R10 id A0=1 first", b, 8'h17);
        get(b); check(b == 8'h5E, "R10 id A0=1 second", b, 8'h5E);
        frame_end();

        // R11: three-byte identifier, repeating
        frame_begin();
        put(8'h9F);
        get(b); check(b == 8'h5E, "R11 jid byte0", b, 8'h5E);
        get(b); check(b == 8'h26, "R11 jid byte1", b, 8'h26);
        get(b); check(b == 8'h14, "R11 jid byte2", b, 8'h14);
        get(b); check(b == 8'h5E, "R11 jid wrap", b, 8'h5E);
        frame_end();

        // R5: program cut off mid data byte
        p0 = pulses;
        frame_begin();
        put(8'h02); put_addr(24'h000010);
        xfer(8'hAA, b, 1'b0, 4);
        frame_end();
        check(pulses == p0, "R5 partial byte ignored", pulses - p0, 0);

        // R5: erase with an extra byte
        p0 = pulses;
        frame_begin();
        put(8'h20); put_addr(24'h00F000); put(8'h00);
        frame_end();
        check(pulses == p0, "R5 extra byte ignored", pulses - p0, 0);

        // R14: last bit together with enable rise commits
        p0 = pulses;
        frame_begin();
        put(8'h01);
        xfer(8'h77, b, 1'b1, 8);
        repeat (8) @(negedge clk);
        check(pulses == p0 + 1, "R14 coincident commit", pulses - p0, 1);
        check(cap_kind == 3'd6 && cap_data == 8'h77, "R14 coincident fields", {cap_kind, cap_data}, {3'd6, 8'h77});

        // R5: one extra bit together with enable rise after chip erase
        p0 = pulses;
        frame_begin();
        put(8'h60);
        xfer(8'h80, b, 1'b1, 1);
        repeat (8) @(negedge clk);
        check(pulses == p0, "R5 extra bit with rise ignored", pulses - p0, 0);

        check(hi_cycles == pulses, "R6 strobe width final", hi_cycles, pulses);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule